// File: doc/BRIEF.md
# Dual-Strobe Scan State Register

This block is the state register of a sequential circuit, built so that the circuit can be tested through a serial scan path. Each storage bit has two data inputs. The functional input takes the next-state value from the circuit's combinational logic when the system-capture enable is high. The scan input takes the value of the preceding bit when the test-shift enable is high. Together the scan inputs form a serial chain that runs from a scan-data input to a scan-data output. Both strobes are synchronous enables on a single clock. Functional capture and serial shift are separate operations, and neither one is a mode of the other.

A test step uses the block in four stages. First, a chosen state is shifted in bit by bit. Next, the primary inputs are applied and the outputs of the circuit are checked. Then the system capture is pulsed once. Finally, the captured state is shifted out serially and compared with the expected value. The serial output is a dedicated register that loads only on a shift cycle, so a functional capture cannot disturb a value that is partly unloaded. The parameter `WIDTH` sets the number of bits and must be at least 2.

Top module: `scan_path_reg`

## Requirements
- R1: When `rst` is high at a clock edge, every bit of `state_q` and `scan_out` becomes 0, whatever the two enables are.
- R2: With `sys_cap_en` high and `tst_shift_en` low, `state_q` takes the value of `next_state` at the clock edge.
- R3: With `tst_shift_en` high, the register shifts by one position toward the high index: bit 0 takes `scan_in`, and bit i takes the old bit i-1.
- R4: When both enables are high in the same cycle, the shift of R3 happens and `next_state` has no effect.
- R5: With both enables low, `state_q` keeps its value.
- R6: On a shift cycle `scan_out` takes the value that bit WIDTH-1 held before the shift. In every other cycle `scan_out` holds, and this includes capture cycles.
- R7: A full test step works end to end. Shifting in WIDTH bits, with the bit destined for index WIDTH-1 first, loads a chosen state. One capture then loads `next_state`. WIDTH further shifts present the captured bits on `scan_out` from the highest index down to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sys_cap_en | input | 1 | System-capture enable: loads `next_state` |
| tst_shift_en | input | 1 | Test-shift enable: shifts the chain by one bit |
| next_state | input | WIDTH | Next-state value from the combinational logic |
| scan_in | input | 1 | Serial scan data into bit 0 |
| state_q | output | WIDTH | Parallel state |
| scan_out | output | 1 | Serial scan data out, registered |

## Verification
The first pattern is capture alone with alternating and all-ones vectors. It shows that the functional port loads the vector as it is, with no bit movement. Shifts of an asymmetric serial pattern establish the chain direction and which end is bit 0. A pattern that applied the bits in reverse, or that shifted the wrong way, would produce a different word. With both enables high and a `next_state` that differs from the shift result, the bench can tell which strobe won. Idle cycles and capture cycles that happen between shifts show that `scan_out` holds while `state_q` changes. A complete load, capture and unload sequence then rebuilds the captured word from the serial stream.

// File: rtl/scan_path_pkg.sv
package scan_path_pkg;

  // Operation selected for every cell in a given cycle
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CAP   = 2'd1,
    OP_SHIFT = 2'd2,
    OP_CLR   = 2'd3
  } scan_op_e;

  // Priority: reset, then test shift, then system capture
  function automatic scan_op_e pick_op(input logic rst, input logic cap,
                                       input logic sft);
    if (rst)      return OP_CLR;
    else if (sft) return OP_SHIFT;
    else if (cap) return OP_CAP;
    else          return OP_HOLD;
  endfunction

endpackage

// File: rtl/dual_port_cell.sv
module dual_port_cell
  import scan_path_pkg::*;
(
  input  logic     clk,
  input  scan_op_e op,
  input  logic     d_sys,
  input  logic     d_scan,
  output logic     q
);

  always_ff @(posedge clk) begin
    case (op)
      OP_CLR:   q <= 1'b0;
      OP_SHIFT: q <= d_scan;
      OP_CAP:   q <= d_sys;
      default:  q <= q;
    endcase
  end

endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import scan_path_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  scan_op_e         op,
  input  logic [WIDTH-1:0] sys_d,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);

  // link[i] feeds the scan port of cell i
  logic [WIDTH-1:0] link;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign link[i] = ser_in;
      end else begin : g_body
        assign link[i] = q[i-1];
      end
      dual_port_cell u_cell (
        .clk    (clk),
        .op     (op),
        .d_sys  (sys_d[i]),
        .d_scan (link[i]),
        .q      (q[i])
      );
    end
  endgenerate

endmodule

// File: rtl/scan_out_stage.sv
module scan_out_stage
  import scan_path_pkg::*;
(
  input  logic     clk,
  input  scan_op_e op,
  input  logic     tail_bit,
  output logic     ser_out
);

  always_ff @(posedge clk) begin
    if (op == OP_CLR)        ser_out <= 1'b0;
    else if (op == OP_SHIFT) ser_out <= tail_bit;
  end

endmodule

// File: rtl/scan_path_reg.sv
module scan_path_reg
  import scan_path_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_cap_en,
  input  logic             tst_shift_en,
  input  logic [WIDTH-1:0] next_state,
  input  logic             scan_in,
  output logic [WIDTH-1:0] state_q,
  output logic             scan_out
);

  localparam int TAIL = WIDTH - 1;

  // Expected chain contents after one shift (used by the checks)
  function automatic logic [WIDTH-1:0] after_shift(input logic [WIDTH-1:0] v,
                                                   input logic s);
    return {v[WIDTH-2:0], s};
  endfunction

  scan_op_e op;
  logic     shift_fire;
  logic     cap_fire;

  assign op         = pick_op(rst, sys_cap_en, tst_shift_en);
  assign shift_fire = (op == OP_SHIFT);
  assign cap_fire   = (op == OP_CAP);

  scan_chain #(.WIDTH(WIDTH)) u_chain (
    .clk    (clk),
    .op     (op),
    .sys_d  (next_state),
    .ser_in (scan_in),
    .q      (state_q)
  );

  scan_out_stage u_out (
    .clk      (clk),
    .op       (op),
    .tail_bit (state_q[TAIL]),
    .ser_out  (scan_out)
  );

  // R1: reset clears state and serial output
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (state_q == '0) && (scan_out == 1'b0));

  // R2: capture alone loads next_state
  p_capture_loads_r2: assert property (@(posedge clk) disable iff (rst)
    (sys_cap_en && !tst_shift_en) |=> state_q == $past(next_state));

  // R3: shift moves the chain by one toward the high index
  p_shift_moves_r3: assert property (@(posedge clk) disable iff (rst)
    tst_shift_en |=> state_q == after_shift($past(state_q), $past(scan_in)));

  // R4: with both enables high, the capture is not taken
  p_shift_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (sys_cap_en && tst_shift_en) |=> !$past(cap_fire) && $past(shift_fire));

  // R5: idle cycle holds the state
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!sys_cap_en && !tst_shift_en) |=> $stable(state_q));

  // R6: serial output holds off shift cycles
  p_sout_holds_r6: assert property (@(posedge clk) disable iff (rst)
    !tst_shift_en |=> $stable(scan_out));

  // R6: serial output takes the old tail bit on a shift
  p_sout_tail_r6: assert property (@(posedge clk) disable iff (rst)
    tst_shift_en |=> scan_out == $past(state_q[TAIL]));

endmodule

// File: tb/scan_path_reg_test.sv
`timescale 1ns/1ps
module scan_path_reg_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sys_cap_en = 1'b0;
  logic         tst_shift_en = 1'b0;
  logic [W-1:0] next_state = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] state_q;
  logic         scan_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Bench model of the register
  logic [W-1:0] m_state = '0;
  logic         m_out   = 1'b0;

  always #5 clk = ~clk;

  scan_path_reg #(.WIDTH(W)) uut (
    .clk          (clk),
    .rst          (rst),
    .sys_cap_en   (sys_cap_en),
    .tst_shift_en (tst_shift_en),
    .next_state   (next_state),
    .scan_in      (scan_in),
    .state_q      (state_q),
    .scan_out     (scan_out)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock with the given inputs; the model advances alongside
  task automatic step(input logic r, input logic cap, input logic sft,
                      input logic [W-1:0] ns, input logic si);
    @(negedge clk);
    rst = r; sys_cap_en = cap; tst_shift_en = sft;
    next_state = ns; scan_in = si;
    @(posedge clk);
    #1;
    if (r) begin
      m_state = '0; m_out = 1'b0;
    end else if (sft) begin
      m_out   = m_state[W-1];
      m_state = {m_state[W-2:0], si};
    end else if (cap) begin
      m_state = ns;
    end
  endtask

  task automatic check_model(input string req);
    check({req, " state"}, 32'(state_q), 32'(m_state));
    check({req, " sout"},  32'(scan_out), 32'(m_out));
  endtask

  task automatic t_reset_r1();
    step(1'b0, 1'b1, 1'b0, 8'hA5, 1'b0);
    step(1'b0, 1'b0, 1'b1, '0, 1'b1);
    step(1'b1, 1'b1, 1'b1, 8'hFF, 1'b1);
    check("R1 state", 32'(state_q), 32'h0);
    check("R1 sout",  32'(scan_out), 32'h0);
  endtask

  task automatic t_capture_r2();
    step(1'b0, 1'b1, 1'b0, 8'h5A, 1'b1);
    check("R2 cap 5A", 32'(state_q), 32'h5A);
    step(1'b0, 1'b1, 1'b0, 8'hFF, 1'b0);
    check("R2 cap FF", 32'(state_q), 32'hFF);
    check("R2 sout unchanged", 32'(scan_out), 32'h0);
  endtask

  task automatic t_shift_r3();
    step(1'b1, 1'b0, 1'b0, '0, 1'b0);
    // bits 1,1,0,1 enter bit 0 in that order -> state 0b1101
    step(1'b0, 1'b0, 1'b1, '0, 1'b1);
    check("R3 first bit", 32'(state_q), 32'h01);
    step(1'b0, 1'b0, 1'b1, '0, 1'b1);
    step(1'b0, 1'b0, 1'b1, '0, 1'b0);
    step(1'b0, 1'b0, 1'b1, '0, 1'b1);
    check("R3 pattern", 32'(state_q), 32'h0D);
    check_model("R3");
  endtask

  task automatic t_both_r4();
    step(1'b0, 1'b1, 1'b0, 8'h81, 1'b0);
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    check("R4 shift wins", 32'(state_q), 32'h02);
    check("R4 sout", 32'(scan_out), 32'h1);
    step(1'b0, 1'b1, 1'b1, 8'hFF, 1'b1);
    check("R4 next_state ignored", 32'(state_q), 32'h05);
  endtask

  task automatic t_hold_r5();
    step(1'b0, 1'b1, 1'b0, 8'hC3, 1'b0);
    step(1'b0, 1'b0, 1'b0, 8'h3C, 1'b1);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R5 hold", 32'(state_q), 32'hC3);
    check_model("R5");
  endtask

  task automatic t_sout_r6();
    step(1'b1, 1'b0, 1'b0, '0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'h80, 1'b0);
    check("R6 no change on capture", 32'(scan_out), 32'h0);
    step(1'b0, 1'b0, 1'b1, '0, 1'b0);
    check("R6 takes tail", 32'(scan_out), 32'h1);
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    check("R6 holds over capture", 32'(scan_out), 32'h1);
    step(1'b0, 1'b0, 1'b0, '0, 1'b0);
    check("R6 holds idle", 32'(scan_out), 32'h1);
    step(1'b0, 1'b0, 1'b1, '0, 1'b0);
    check("R6 takes zero tail", 32'(scan_out), 32'h0);
  endtask

  task automatic t_test_step_r7(input logic [W-1:0] load,
                                input logic [W-1:0] cap);
    logic [W-1:0] got;
    step(1'b1, 1'b0, 1'b0, '0, 1'b0);
    for (int k = 0; k < W; k++) step(1'b0, 1'b0, 1'b1, '0, load[W-1-k]);
    check("R7 loaded", 32'(state_q), 32'(load));
    step(1'b0, 1'b1, 1'b0, cap, 1'b0);
    check("R7 captured", 32'(state_q), 32'(cap));
    got = '0;
    for (int k = 0; k < W; k++) begin
      step(1'b0, 1'b0, 1'b1, '0, 1'b0);
      got[W-1-k] = scan_out;
    end
    check("R7 unloaded", 32'(got), 32'(cap));
    check("R7 chain empty", 32'(state_q), 32'h0);
  endtask

  initial begin
    #20000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(1'b1, 1'b0, 1'b0, '0, 1'b0);
    step(1'b1, 1'b0, 1'b0, '0, 1'b0);
    check("R1 initial state", 32'(state_q), 32'h0);
    check("R1 initial sout",  32'(scan_out), 32'h0);
    t_reset_r1();
    t_capture_r2();
    t_shift_r3();
    t_both_r4();
    t_hold_r5();
    t_sout_r6();
    t_test_step_r7(8'hB4, 8'h6D);
    t_test_step_r7(8'h01, 8'h80);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end

endmodule